// File: doc/BRIEF.md
# Keyed Refresh Unlock Guard for a Watchdog

This block stands in front of a watchdog's refresh (kick) register and decides whether a kick write is honoured. With the guard enabled, software must first write a 16-bit unlock word that matches an expected value, then write the 32-bit kick key 0x5A45524F. The expected value is picked by a 2-bit method field from four schemes: the stored password itself, the password rotated left by one bit, a fixed constant, or a chained value that evolves on every consumed unlock. A wrong unlock word raises an unlock-fail event. A kick written while locked, or a kick write carrying any other value, raises a violation event and produces no kick.

Writes arrive on a plain strobe/address/data port whose address decoding is done outside. Address 0 is the configuration word, address 1 the unlock word, address 2 the kick, and address 3 reaches nothing. The configuration word holds the password, the method, the guard enable and four routing enables that steer each event to an interrupt request and/or a reset request. The watchdog counter, the timing window and the bus fabric are outside this block. The block emits only a one-cycle kick strobe for the counter, the two event pulses and the two request lines.

The controller has two states. LOCKED is entered at reset and on any configuration write. OPEN is entered from LOCKED (or held) when a matching unlock word arrives. The transitions are: *unlock-match* (LOCKED/OPEN to OPEN), *unlock-miss* (LOCKED/OPEN to LOCKED with an unlock-fail event), *kick-consume* (OPEN to LOCKED, with either a kick or a violation), *kick-while-locked* (LOCKED to LOCKED with a violation) and *reconfigure* (any state to LOCKED).

Top module: `uwd_refresh_guard`

## Requirements
- R1: After reset the password is 0xED09, the method is 0, the guard is enabled, all routing enables are 0, the state is LOCKED and every output is low.
- R2: With method 0, the unlock word on wr_data[15:0] is accepted only if it equals the stored password exactly.
- R3: With method 1, the accepted unlock word is the password rotated left by one bit, {pw[14:0], pw[15]} (0xDA13 for password 0xED09), and the plain password is rejected.
- R4: With method 2, the accepted unlock word is 0x55AA whatever the password is.
- R5: With method 3, the accepted word is {last[14:0], last[15] ^ pw[0]}. last is loaded with the password on every configuration write and replaced by the accepted word each time an unlock is consumed by a kick write.
- R6: In state OPEN with the guard enabled, a write of 0x5A45524F to address 2 makes kick_o high for exactly one cycle, in the cycle after the write.
- R7: A non-matching unlock word while the guard is enabled pulses evt_o[1] (unlock fail) in the cycle after the write and leaves the block LOCKED.
- R8: A kick write while LOCKED, or any kick value other than 0x5A45524F, pulses evt_o[0] (violation) in the cycle after the write with no kick. A single write never produces more than one of kick_o, evt_o[1] and evt_o[0].
- R9: An unlock is consumed by one kick write whatever its value. The next kick write without a new unlock is a violation.
- R10: With the guard disabled (config bit 18 = 0), the key alone kicks, any other kick value is a violation, unlock writes raise no event, and the state never becomes OPEN.
- R11: Configuration bits 20 and 21 route unlock-fail to irq_o and rst_req_o respectively. Bits 22 and 23 route violation to irq_o and rst_req_o respectively. The request lines are high in the same cycle as the routed event pulse.
- R12: A configuration write (password in bits 15:0, method in bits 17:16) returns the block to LOCKED, so a pending unlock is lost. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | 0 config, 1 unlock, 2 kick, 3 unused |
| wr_data | input | 32 | Write data |
| kick_o | output | 1 | One-cycle refresh strobe to the watchdog counter |
| evt_o | output | 2 | Event pulses: bit 1 unlock fail, bit 0 violation |
| irq_o | output | 1 | Interrupt request from routed events |
| rst_req_o | output | 1 | Reset request from routed events |

## Verification
The bench builds the block with its default parameters: a 16-bit password, a 32-bit data word, key 0x5A45524F, fixed word 0x55AA and reset password 0xED09. These are the values on which the method arithmetic, the bit-15 rotation and the chained update can be checked against hand-known words such as 0xDA13. The 16-bit width puts the wrap of bit 15 into bit 0, and the XOR with the password's bit 0, within direct reach. It also gives a chain of three consumed unlocks on a password with both end bits set. The routing enables are exercised alone and together, and the guard is switched off and back on.

// File: rtl/uwd_pkg.sv
package uwd_pkg;

    typedef enum logic [1:0] {
        UWD_A_CFG    = 2'd0,
        UWD_A_UNLOCK = 2'd1,
        UWD_A_KICK   = 2'd2,
        UWD_A_NONE   = 2'd3
    } uwd_addr_e;

    typedef enum logic [1:0] {
        UWD_M_DIRECT = 2'd0,
        UWD_M_ROTATE = 2'd1,
        UWD_M_FIXED  = 2'd2,
        UWD_M_CHAIN  = 2'd3
    } uwd_method_e;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } uwd_state_e;

    // configuration word field positions
    localparam int CFG_METH_LO = 16;
    localparam int CFG_GUARD   = 18;
    localparam int CFG_UF_IRQ  = 20;
    localparam int CFG_UF_RST  = 21;
    localparam int CFG_RV_IRQ  = 22;
    localparam int CFG_RV_RST  = 23;

    // event vector positions
    localparam int EV_RV = 0;
    localparam int EV_UF = 1;

    typedef struct packed {
        logic uf_irq;
        logic uf_rst;
        logic rv_irq;
        logic rv_rst;
    } uwd_route_t;

endpackage

// File: rtl/uwd_cfg_regs.sv
module uwd_cfg_regs
    import uwd_pkg::*;
#(
    parameter int            PW_W   = 16,
    parameter int            DATA_W = 32,
    parameter logic [PW_W-1:0] RST_PW = 16'hED09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [PW_W-1:0]   pw,
    output uwd_method_e       method,
    output logic              guard_en,
    output uwd_route_t        route
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pw       <= RST_PW;
            method   <= UWD_M_DIRECT;
            guard_en <= 1'b1;
            route    <= '0;
        end else if (cfg_we) begin
            pw            <= wdata[PW_W-1:0];
            method        <= uwd_method_e'(wdata[CFG_METH_LO+1:CFG_METH_LO]);
            guard_en      <= wdata[CFG_GUARD];
            route.uf_irq  <= wdata[CFG_UF_IRQ];
            route.uf_rst  <= wdata[CFG_UF_RST];
            route.rv_irq  <= wdata[CFG_RV_IRQ];
            route.rv_rst  <= wdata[CFG_RV_RST];
        end
    end

endmodule

// File: rtl/uwd_expect_gen.sv
module uwd_expect_gen
    import uwd_pkg::*;
#(
    parameter int              PW_W      = 16,
    parameter logic [PW_W-1:0] FIXED_WORD = 16'h55AA,
    parameter logic [PW_W-1:0] RST_PW    = 16'hED09
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [PW_W-1:0] new_pw,
    input  logic            consume,
    input  logic [PW_W-1:0] pw,
    input  uwd_method_e     method,
    output logic [PW_W-1:0] exp_word
);

    localparam int TOP = PW_W - 1;

    logic [PW_W-1:0] last_q;
    logic [PW_W-1:0] rot_w;
    logic [PW_W-1:0] chain_w;

    assign rot_w   = {pw[TOP-1:0], pw[TOP]};
    assign chain_w = {last_q[TOP-1:0], last_q[TOP] ^ pw[0]};

    always_comb begin
        unique case (method)
            UWD_M_DIRECT: exp_word = pw;
            UWD_M_ROTATE: exp_word = rot_w;
            UWD_M_FIXED:  exp_word = FIXED_WORD;
            UWD_M_CHAIN:  exp_word = chain_w;
            default:      exp_word = pw;
        endcase
    end

    // history of the chained scheme: seeded from the password, advanced per consumed unlock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= RST_PW;
        end else if (cfg_we) begin
            last_q <= new_pw;
        end else if (consume) begin
            last_q <= exp_word;
        end
    end

endmodule

// File: rtl/uwd_fsm.sv
module uwd_fsm
    import uwd_pkg::*;
#(
    parameter int                PW_W     = 16,
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] KICK_KEY = 32'h5A45524F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              guard_en,
    input  logic [PW_W-1:0]   exp_word,
    output uwd_state_e        st,
    output logic              consume,
    output logic              kick_q,
    output logic [1:0]        evt_q
);

    uwd_state_e st_nxt;
    logic       kick_nxt;
    logic       uf_nxt;
    logic       rv_nxt;
    logic       key_ok;
    logic       word_ok;

    assign key_ok  = (wr_data == KICK_KEY);
    assign word_ok = (wr_data[PW_W-1:0] == exp_word);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_LOCKED;
        end else begin
            st <= st_nxt;
        end
    end

    // transition decisions
    always_comb begin
        st_nxt   = st;
        consume  = 1'b0;
        kick_nxt = 1'b0;
        uf_nxt   = 1'b0;
        rv_nxt   = 1'b0;
        if (wr_en) begin
            case (uwd_addr_e'(wr_addr))
                UWD_A_CFG: begin
                    st_nxt = ST_LOCKED;                 // reconfigure
                end
                UWD_A_UNLOCK: begin
                    if (guard_en) begin
                        if (word_ok) begin
                            st_nxt = ST_OPEN;           // unlock-match
                        end else begin
                            st_nxt = ST_LOCKED;         // unlock-miss
                            uf_nxt = 1'b1;
                        end
                    end
                end
                UWD_A_KICK: begin
                    if (!guard_en) begin
                        kick_nxt = key_ok;
                        rv_nxt   = !key_ok;
                    end else begin
                        unique case (st)
                            ST_LOCKED: begin
                                rv_nxt = 1'b1;          // kick-while-locked
                            end
                            ST_OPEN: begin
                                st_nxt   = ST_LOCKED;   // kick-consume
                                consume  = 1'b1;
                                kick_nxt = key_ok;
                                rv_nxt   = !key_ok;
                            end
                            default: rv_nxt = 1'b1;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kick_q <= 1'b0;
            evt_q  <= '0;
        end else begin
            kick_q       <= kick_nxt;
            evt_q[EV_UF] <= uf_nxt;
            evt_q[EV_RV] <= rv_nxt;
        end
    end

endmodule

// File: rtl/uwd_evt_route.sv
module uwd_evt_route
    import uwd_pkg::*;
(
    input  logic [1:0] evt,
    input  uwd_route_t route,
    output logic       irq,
    output logic       rst_req
);

    assign irq     = (evt[EV_UF] & route.uf_irq) | (evt[EV_RV] & route.rv_irq);
    assign rst_req = (evt[EV_UF] & route.uf_rst) | (evt[EV_RV] & route.rv_rst);

endmodule

// File: rtl/uwd_refresh_guard.sv
module uwd_refresh_guard
    import uwd_pkg::*;
#(
    parameter int                PW_W       = 16,
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] KICK_KEY   = 32'h5A45524F,
    parameter logic [PW_W-1:0]   FIXED_WORD = 16'h55AA,
    parameter logic [PW_W-1:0]   RST_PW     = 16'hED09
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              kick_o,
    output logic [1:0]        evt_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    logic            cfg_we;
    logic [PW_W-1:0] pw;
    uwd_method_e     method;
    logic            guard_en;
    uwd_route_t      route;
    logic [PW_W-1:0] exp_word;
    uwd_state_e      st;
    logic            consume;

    assign cfg_we = wr_en && (wr_addr == UWD_A_CFG);

    uwd_cfg_regs #(.PW_W(PW_W), .DATA_W(DATA_W), .RST_PW(RST_PW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .wdata    (wr_data),
        .pw       (pw),
        .method   (method),
        .guard_en (guard_en),
        .route    (route)
    );

    uwd_expect_gen #(.PW_W(PW_W), .FIXED_WORD(FIXED_WORD), .RST_PW(RST_PW)) u_exp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .new_pw   (wr_data[PW_W-1:0]),
        .consume  (consume),
        .pw       (pw),
        .method   (method),
        .exp_word (exp_word)
    );

    uwd_fsm #(.PW_W(PW_W), .DATA_W(DATA_W), .KICK_KEY(KICK_KEY)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .guard_en (guard_en),
        .exp_word (exp_word),
        .st       (st),
        .consume  (consume),
        .kick_q   (kick_o),
        .evt_q    (evt_o)
    );

    uwd_evt_route u_route (
        .evt     (evt_o),
        .route   (route),
        .irq     (irq_o),
        .rst_req (rst_req_o)
    );

endmodule

// File: rtl/uwd_chk.sv
module uwd_chk #(
    parameter int                PW_W     = 16,
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] KICK_KEY = 32'h5A45524F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              guard_en,
    input logic              st_open,
    input logic [PW_W-1:0]   exp_word,
    input logic              kick_o,
    input logic [1:0]        evt_o
);

    a_r6_open_key_kicks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && guard_en && st_open && wr_data == KICK_KEY) |=> kick_o);

    a_r7_bad_word_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && guard_en && wr_data[PW_W-1:0] != exp_word) |=> (evt_o[1] && !st_open));

    a_r8_locked_kick_violates: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && guard_en && !st_open) |=> (evt_o[0] && !kick_o));

    a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kick_o, evt_o}));

    a_r9_kick_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && guard_en && st_open) |=> !st_open);

    a_r10_open_needs_guard: assert property (@(posedge clk) disable iff (!rst_n)
        st_open |-> guard_en);

    a_r10_no_fail_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && !guard_en) |=> !evt_o[1]);

    a_r12_cfg_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> (!st_open && !kick_o && evt_o == 2'b00));

endmodule

bind uwd_refresh_guard uwd_chk #(.PW_W(PW_W), .DATA_W(DATA_W), .KICK_KEY(KICK_KEY)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .guard_en (guard_en),
    .st_open  (st == uwd_pkg::ST_OPEN),
    .exp_word (exp_word),
    .kick_o   (kick_o),
    .evt_o    (evt_o)
);

// File: tb/tb_uwd_refresh_guard.sv
`timescale 1ns/1ps
module tb_uwd_refresh_guard;

    localparam logic [31:0] KEY = 32'h5A45524F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd3;
    logic [31:0] wr_data = '0;
    logic        kick_o;
    logic [1:0]  evt_o;
    logic        irq_o;
    logic        rst_req_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    uwd_refresh_guard dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .kick_o(kick_o), .evt_o(evt_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    // behavioural reference model
    logic [15:0] m_pw = 16'hED09;
    logic [15:0] m_last = 16'hED09;
    logic [1:0]  m_meth = 2'd0;
    logic        m_guard = 1'b1;
    logic [3:0]  m_en = 4'd0;       // {rv_rst, rv_irq, uf_rst, uf_irq}
    logic        m_open = 1'b0;
    logic        m_kick = 1'b0;
    logic        m_uf = 1'b0;
    logic        m_rv = 1'b0;

    function automatic logic [15:0] want(input logic [1:0] meth, input logic [15:0] pw,
                                         input logic [15:0] last);
        case (meth)
            2'd0: return pw;
            2'd1: return {pw[14:0], pw[15]};
            2'd2: return 16'h55AA;
            default: return {last[14:0], last[15] ^ pw[0]};
        endcase
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pw = 16'hED09; m_last = 16'hED09; m_meth = 0; m_guard = 1; m_en = 0;
            m_open = 0; m_kick = 0; m_uf = 0; m_rv = 0;
        end else begin
            m_kick = 0; m_uf = 0; m_rv = 0;
            if (wr_en) begin
                if (wr_addr == 2'd0) begin
                    m_pw = wr_data[15:0]; m_meth = wr_data[17:16]; m_guard = wr_data[18];
                    m_en = wr_data[23:20]; m_last = wr_data[15:0]; m_open = 0;
                end else if (wr_addr == 2'd1) begin
                    if (m_guard) begin
                        if (wr_data[15:0] == want(m_meth, m_pw, m_last)) m_open = 1;
                        else begin m_open = 0; m_uf = 1; end
                    end
                end else if (wr_addr == 2'd2) begin
                    if (!m_guard) begin
                        if (wr_data == KEY) m_kick = 1; else m_rv = 1;
                    end else if (!m_open) begin
                        m_rv = 1;
                    end else begin
                        m_last = want(m_meth, m_pw, m_last);
                        m_open = 0;
                        if (wr_data == KEY) m_kick = 1; else m_rv = 1;
                    end
                end
            end
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        logic e_irq, e_rst;
        e_irq = (m_uf & m_en[0]) | (m_rv & m_en[2]);
        e_rst = (m_uf & m_en[1]) | (m_rv & m_en[3]);
        checks++;
        if (kick_o !== m_kick || evt_o !== {m_uf, m_rv} || irq_o !== e_irq || rst_req_o !== e_rst) begin
            errors++;
            $display("FAIL R6/R7/R8/R11 model cycle %0d: kick=%b evt=%b irq=%b rst=%b expected kick=%b evt=%b irq=%b rst=%b",
                     cyc, kick_o, evt_o, irq_o, rst_req_o, m_kick, {m_uf, m_rv}, e_irq, e_rst);
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements): run still going at cycle %0d, expected end", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // drive one write, then sample its outcome one cycle later
    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag,
                      input logic ek, input logic euf, input logic erv);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd3;
        checks++;
        if (kick_o !== ek || evt_o !== {euf, erv}) begin
            errors++;
            $display("FAIL %s: kick=%b evt=%b expected kick=%b evt=%b", tag, kick_o, evt_o, ek, {euf, erv});
        end
    endtask

    task automatic req_chk(input string tag, input logic ei, input logic er);
        checks++;
        if (irq_o !== ei || rst_req_o !== er) begin
            errors++;
            $display("FAIL %s: irq=%b rst=%b expected irq=%b rst=%b", tag, irq_o, rst_req_o, ei, er);
        end
    endtask

    function automatic logic [31:0] cfg(input logic [15:0] pw, input logic [1:0] meth,
                                         input logic guard, input logic [3:0] en);
        return {8'h00, en, 1'b0, guard, meth, pw};
    endfunction

    initial begin
        logic [15:0] last;
        logic [15:0] nxt;
        repeat (3) @(negedge clk);
        checks++;
        if (kick_o !== 0 || evt_o !== 0 || irq_o !== 0 || rst_req_o !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs: %b%b%b%b expected 0000", kick_o, evt_o, irq_o, rst_req_o);
        end
        rst_n = 1'b1;

        // R1/R2: default password, direct method
        wr(2'd1, 32'h0000ED09, "R1 R2 default password unlock", 0, 0, 0);
        wr(2'd2, KEY, "R6 key after unlock", 1, 0, 0);
        wr(2'd2, KEY, "R9 second key without unlock", 0, 0, 1);
        wr(2'd1, 32'h00001234, "R7 wrong unlock word", 0, 1, 0);
        wr(2'd2, KEY, "R8 key while locked", 0, 0, 1);
        wr(2'd1, 32'hFFFFED09, "R2 upper bits ignored", 0, 0, 0);
        wr(2'd2, 32'h5A45524E, "R8 wrong key value", 0, 0, 1);
        wr(2'd2, KEY, "R9 unlock consumed by bad kick", 0, 0, 1);

        // R3 rotate
        wr(2'd0, cfg(16'hED09, 2'd1, 1, 0), "R12 cfg method 1", 0, 0, 0);
        wr(2'd1, 32'h0000ED09, "R3 plain password rejected", 0, 1, 0);
        wr(2'd1, 32'h0000DA13, "R3 rotated word", 0, 0, 0);
        wr(2'd2, KEY, "R3 kick after rotated unlock", 1, 0, 0);

        // R4 fixed
        wr(2'd0, cfg(16'h0000, 2'd2, 1, 0), "R12 cfg method 2", 0, 0, 0);
        wr(2'd1, 32'h00000000, "R4 password ignored", 0, 1, 0);
        wr(2'd1, 32'h000055AA, "R4 fixed word", 0, 0, 0);
        wr(2'd2, KEY, "R4 kick after fixed unlock", 1, 0, 0);

        // R5 chain
        wr(2'd0, cfg(16'h8235, 2'd3, 1, 0), "R12 cfg method 3", 0, 0, 0);
        last = 16'h8235;
        for (int i = 0; i < 3; i++) begin
            nxt = {last[14:0], last[15] ^ 1'b1};
            wr(2'd1, {16'h0, last}, "R5 stale chain word rejected", 0, (last != nxt), 0);
            wr(2'd1, {16'h0, nxt}, "R5 chain word accepted", 0, 0, 0);
            wr(2'd2, KEY, "R5 kick on chain", 1, 0, 0);
            last = nxt;
        end
        wr(2'd1, 32'h0000_0000 | {16'h0, {last[14:0], last[15] ^ 1'b1}}, "R5 chain continues", 0, 0, 0);
        wr(2'd2, 32'h0, "R9 bad kick still advances", 0, 0, 1);
        last = {last[14:0], last[15] ^ 1'b1};
        wr(2'd1, {16'h0, {last[14:0], last[15] ^ 1'b1}}, "R5 advanced after bad kick", 0, 0, 0);
        wr(2'd2, KEY, "R5 kick", 1, 0, 0);

        // R10 guard disabled
        wr(2'd0, cfg(16'hED09, 2'd0, 0, 0), "R12 cfg guard off", 0, 0, 0);
        wr(2'd2, KEY, "R10 key alone kicks", 1, 0, 0);
        wr(2'd1, 32'h00000001, "R10 unlock ignored", 0, 0, 0);
        wr(2'd2, 32'h12345678, "R10 bad key violation", 0, 0, 1);

        // R11 routing
        wr(2'd0, cfg(16'hED09, 2'd0, 1, 4'b1111), "R12 cfg all routes", 0, 0, 0);
        wr(2'd1, 32'h00000002, "R11 unlock fail routed", 0, 1, 0);
        req_chk("R11 uf both requests", 1, 1);
        wr(2'd2, KEY, "R11 violation routed", 0, 0, 1);
        req_chk("R11 rv both requests", 1, 1);
        wr(2'd0, cfg(16'hED09, 2'd0, 1, 4'b0001), "R12 cfg uf irq only", 0, 0, 0);
        wr(2'd1, 32'h00000002, "R11 uf irq only", 0, 1, 0);
        req_chk("R11 uf irq only", 1, 0);
        wr(2'd2, KEY, "R11 rv unrouted", 0, 0, 1);
        req_chk("R11 rv unrouted", 0, 0);
        wr(2'd0, cfg(16'hED09, 2'd0, 1, 4'b1000), "R12 cfg rv rst only", 0, 0, 0);
        wr(2'd2, KEY, "R11 rv reset only", 0, 0, 1);
        req_chk("R11 rv reset only", 0, 1);

        // R12 relock and unused address
        wr(2'd1, 32'h0000ED09, "R12 unlock before cfg", 0, 0, 0);
        wr(2'd0, cfg(16'hED09, 2'd0, 1, 0), "R12 cfg while open", 0, 0, 0);
        wr(2'd2, KEY, "R12 unlock lost by cfg", 0, 0, 1);
        wr(2'd1, 32'h0000ED09, "R12 unlock", 0, 0, 0);
        wr(2'd3, 32'hFFFFFFFF, "R12 address 3 ignored", 0, 0, 0);
        wr(2'd2, KEY, "R12 still open after address 3", 1, 0, 0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule